// File: doc/BRIEF.md
# LCD Polarity Alternation Generator

This block produces the level that flips the polarity of the drive applied to a liquid-crystal panel, so that no net DC bias builds up across the cells. It sits beside the scan timing logic and takes from it two single-cycle strobes: one at the start of each horizontal line and one at the start of each frame. A small programmable register chooses the flip cadence. With a zero rate code the level flips once per frame. With a nonzero code the level flips after a fixed odd number of lines, and the line count carries on across frame boundaries.

Software writes the rate through a simple write strobe with a data byte and reads the rate back on a read-data bus at any time. A write also clears the line count, so the new rate is measured from the write. The output level is held low while the block is in reset and is never changed by a register write.

Top module: `lcd_polarity_gen`

## Requirements
- R1: After reset `ac_level` is 0 and `rate_rdata` is 8'h00.
- R2: `rate_rdata` always shows the rate code in bits [4:0] and 0 in bits [7:5]; a write stores `rate_wdata[4:0]` and discards `rate_wdata[7:5]`.
- R3: With rate code 0, `ac_level` inverts on the clock edge that samples `frame_pulse` high.
- R4: With rate code n in 1..31, `ac_level` inverts on every (2n+1)-th sampled `line_pulse`, so codes 1, 2, 3 give 3, 5, 7 lines and 29, 30, 31 give 59, 61, 63 lines.
- R5: With rate code 0, `line_pulse` has no effect on `ac_level`.
- R6: With a nonzero rate code, `frame_pulse` neither changes `ac_level` nor clears the line count, also when it coincides with `line_pulse`.
- R7: A cycle with `rate_wr` high leaves `ac_level` unchanged and ignores any `line_pulse` or `frame_pulse` in that cycle.
- R8: A write clears the line count: after a write of nonzero code n, the first inversion comes on the (2n+1)-th line pulse after the write, whatever count was reached before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_pulse | input | 1 | One-cycle strobe at each horizontal line |
| frame_pulse | input | 1 | One-cycle strobe at each frame |
| rate_wr | input | 1 | Write strobe for the rate register |
| rate_wdata | input | 8 | Write data; bits [4:0] are the rate code |
| rate_rdata | output | 8 | Read data: rate code zero-extended |
| ac_level | output | 1 | Polarity alternation level |

## Verification
The bench sweeps every nonzero rate code with over two full periods of line pulses and checks the level after each pulse against a period of 2n+1 computed arithmetically; an off-by-one period (2n or 2n+2) or a counter that wraps at the wrong value shows as an early or late flip. Frame strobes are mixed into line mode, alone and together with line strobes, to catch a design that clears the count or flips at frame start. A rate change in mid-count and a write landing on a line strobe are checked, where a design without the clear flips too early and one that honours the strobe in the write cycle counts one line too many. Readback with the upper data bits set catches a register that keeps or echoes them.

// File: rtl/lcd_pol_pkg.sv
package lcd_pol_pkg;

  typedef enum logic {
    MODE_FRAME = 1'b0,
    MODE_LINE  = 1'b1
  } ac_mode_e;

endpackage

// File: rtl/lcd_pol_rstsync.sv
module lcd_pol_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/lcd_pol_regs.sv
module lcd_pol_regs
  import lcd_pol_pkg::*;
#(
  parameter int RATE_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [RATE_W-1:0] rate,
  output ac_mode_e          mode,
  output logic [DATA_W-1:0] rd_data
);

  localparam int PAD_W = DATA_W - RATE_W;

  logic [RATE_W-1:0] rate_q;
  logic [RATE_W-1:0] rate_d;
  logic              unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:RATE_W];

  always_comb begin
    rate_d = rate_q;
    if (wr_en) begin
      rate_d = wr_data[RATE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
    end else begin
      rate_q <= rate_d;
    end
  end

  assign rate    = rate_q;
  assign mode    = (rate_q == '0) ? MODE_FRAME : MODE_LINE;
  assign rd_data = {{PAD_W{1'b0}}, rate_q};

  // R2
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rate == $past(wr_data[RATE_W-1:0]));

  // R2
  rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rate));

endmodule

// File: rtl/lcd_pol_linecnt.sv
module lcd_pol_linecnt
  import lcd_pol_pkg::*;
#(
  parameter int RATE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              line_pulse,
  input  ac_mode_e          mode,
  input  logic [RATE_W-1:0] rate,
  output logic              wrap
);

  localparam int CNT_W = RATE_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] last_val;
  logic             step;
  logic             at_last;

  assign last_val = {rate, 1'b0};
  assign step     = line_pulse && (mode == MODE_LINE) && !clr;
  assign at_last  = (cnt_q == last_val);

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (step) begin
      cnt_d = at_last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign wrap = step && at_last;

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_val);

  // R8
  wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);

  // R6
  frame_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !line_pulse) |=> $stable(cnt_q));

endmodule

// File: rtl/lcd_pol_toggle.sv
module lcd_pol_toggle
  import lcd_pol_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  logic     frame_pulse,
  input  ac_mode_e mode,
  input  logic     wrap,
  output logic     ac
);

  logic ac_q;
  logic ac_d;
  logic frame_flip;

  assign frame_flip = (mode == MODE_FRAME) && frame_pulse && !wr_en;

  always_comb begin
    ac_d = ac_q;
    if (wrap || frame_flip) begin
      ac_d = ~ac_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_q <= 1'b0;
    end else begin
      ac_q <= ac_d;
    end
  end

  assign ac = ac_q;

  // R3
  frame_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_FRAME) && frame_pulse && !wr_en) |=> ac != $past(ac));

  // R6
  line_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_LINE) && !wrap) |=> $stable(ac));

  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> $stable(ac));

endmodule

// File: rtl/lcd_polarity_gen.sv
module lcd_polarity_gen
  import lcd_pol_pkg::*;
#(
  parameter int RATE_W = 5,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_pulse,
  input  logic              frame_pulse,
  input  logic              rate_wr,
  input  logic [DATA_W-1:0] rate_wdata,
  output logic [DATA_W-1:0] rate_rdata,
  output logic              ac_level
);

  logic              rst_sync_n;
  logic [RATE_W-1:0] rate;
  ac_mode_e          mode;
  logic              wrap;

  lcd_pol_rstsync #(.STAGES(SYNC_STAGES)) u_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lcd_pol_regs #(.RATE_W(RATE_W), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (rate_wr),
    .wr_data (rate_wdata),
    .rate    (rate),
    .mode    (mode),
    .rd_data (rate_rdata)
  );

  lcd_pol_linecnt #(.RATE_W(RATE_W)) u_linecnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .clr        (rate_wr),
    .line_pulse (line_pulse),
    .mode       (mode),
    .rate       (rate),
    .wrap       (wrap)
  );

  lcd_pol_toggle u_toggle (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_en       (rate_wr),
    .frame_pulse (frame_pulse),
    .mode        (mode),
    .wrap        (wrap),
    .ac          (ac_level)
  );

  // R5
  line_ignored_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((rate_rdata == '0) && !frame_pulse) |=> $stable(ac_level));

endmodule

// File: tb/test_lcd_polarity_gen.sv
module test_lcd_polarity_gen;

  logic       clk;
  logic       rst_n;
  logic       line_pulse;
  logic       frame_pulse;
  logic       rate_wr;
  logic [7:0] rate_wdata;
  logic [7:0] rate_rdata;
  logic       ac_level;

  int checks;
  int fails;
  logic exp_ac;

  lcd_polarity_gen i_lcd_polarity_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_pulse  (line_pulse),
    .frame_pulse (frame_pulse),
    .rate_wr     (rate_wr),
    .rate_wdata  (rate_wdata),
    .rate_rdata  (rate_rdata),
    .ac_level    (ac_level)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic write_rate(input logic [7:0] d, input logic with_line);
    @(negedge clk);
    rate_wr    = 1'b1;
    rate_wdata = d;
    line_pulse = with_line;
    frame_pulse = with_line;
    @(negedge clk);
    rate_wr     = 1'b0;
    line_pulse  = 1'b0;
    frame_pulse = 1'b0;
  endtask

  task automatic strobe(input logic ln, input logic fr);
    @(negedge clk);
    line_pulse  = ln;
    frame_pulse = fr;
    @(negedge clk);
    line_pulse  = 1'b0;
    frame_pulse = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    checks = 0;
    fails  = 0;
    rst_n = 1'b0;
    line_pulse = 1'b0;
    frame_pulse = 1'b0;
    rate_wr = 1'b0;
    rate_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    exp_ac = 1'b0;
    check("R1 ac", {7'd0, ac_level}, 8'd0);
    check("R1 rdata", rate_rdata, 8'h00);

    // R5: code 0, line pulses ignored
    for (int i = 0; i < 5; i++) begin
      strobe(1'b1, 1'b0);
      check("R5 line ignored", {7'd0, ac_level}, {7'd0, exp_ac});
    end
    // R3: code 0, each frame flips
    for (int i = 0; i < 6; i++) begin
      strobe(1'b0, 1'b1);
      exp_ac = ~exp_ac;
      check("R3 frame flip", {7'd0, ac_level}, {7'd0, exp_ac});
      strobe(1'b1, 1'b1);
      exp_ac = ~exp_ac;
      check("R3 frame+line flip", {7'd0, ac_level}, {7'd0, exp_ac});
    end

    // R4/R6 sweep of every nonzero code
    for (int code = 1; code < 32; code++) begin
      int period;
      int k;
      period = 2 * code + 1;
      write_rate(8'(code), 1'b0);
      check("R2 readback", rate_rdata, 8'(code));
      check("R7 ac kept on write", {7'd0, ac_level}, {7'd0, exp_ac});
      k = 0;
      for (int p = 0; p < 2 * period + 3; p++) begin
        if (p % 3 == 1) begin
          strobe(1'b0, 1'b1);
          check("R6 frame ignored", {7'd0, ac_level}, {7'd0, exp_ac});
        end
        strobe(1'b1, (p % 5 == 2));
        k++;
        if (k % period == 0) exp_ac = ~exp_ac;
        check("R4 line period", {7'd0, ac_level}, {7'd0, exp_ac});
      end
    end

    // R2: upper data bits discarded
    write_rate(8'hE3, 1'b0);
    check("R2 upper bits zero", rate_rdata, 8'h03);

    // R8: mid-count rate change, period 7 -> 5
    for (int p = 0; p < 4; p++) strobe(1'b1, 1'b0);
    check("R8 no wrap yet", {7'd0, ac_level}, {7'd0, exp_ac});
    write_rate(8'h02, 1'b0);
    for (int p = 0; p < 4; p++) begin
      strobe(1'b1, 1'b0);
      check("R8 count cleared", {7'd0, ac_level}, {7'd0, exp_ac});
    end
    strobe(1'b1, 1'b0);
    exp_ac = ~exp_ac;
    check("R8 first wrap after write", {7'd0, ac_level}, {7'd0, exp_ac});

    // R7: write coinciding with line and frame strobes, period 3
    write_rate(8'h01, 1'b1);
    check("R7 write cycle strobes ignored", {7'd0, ac_level}, {7'd0, exp_ac});
    strobe(1'b1, 1'b0);
    strobe(1'b1, 1'b0);
    check("R7 two lines after write", {7'd0, ac_level}, {7'd0, exp_ac});
    strobe(1'b1, 1'b0);
    exp_ac = ~exp_ac;
    check("R7 third line flips", {7'd0, ac_level}, {7'd0, exp_ac});

    // R7: write of code 0 with frame strobe in same cycle
    write_rate(8'h00, 1'b1);
    check("R7 frame in write cycle", {7'd0, ac_level}, {7'd0, exp_ac});
    check("R2 readback zero", rate_rdata, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule